// File: doc/BRIEF.md
# Floppy Controller Host Handshake and Command Admission

This block owns the host-facing flag logic of a floppy disk controller. When the host writes a command, the block decides from the command class and the drive condition pins whether the command may run. A step-type command always runs. A read command needs the drive to be ready. A write command needs the drive to be ready and the medium not to be protected. A rejected command ends at once: the block raises the interrupt flag, pulses a terminate strobe and records the reason in the status byte. An admitted command sets busy until the sequencer reports completion or, for a write, the drive reports a fault while the write gate is open.

While a command runs, the block also drives the data-request flag that paces byte transfers. In a read, the flag rises when the serial logic moves a finished byte into the data register, and it falls when the host reads that register. In a write, the flag rises when the data register has been emptied into the shifter, and it falls when the host loads a new byte. The side-select output holds the side bit of the most recent read or write command. The status byte combines busy, the data request, the three rejection and fault reasons, and the inverted ready pin.

Top module: `fdc_hostflags`

## Requirements
- R1: After reset, `drq`, `intrq`, `busy`, `side_sel` and `terminate` are 0, and status bits 0 to 6 are 0.
- R2: A command write while idle clears `intrq`. If the command is admitted, `busy` and status bit 0 are 1 on the cycle after the write. Command code bit 1 = 0 is the step class. Code `10` is a read. Code `11` is a write.
- R3: A read or write command written while `drv_ready` is low is not admitted. On the next cycle `busy` is 0, `intrq` is 1, `terminate` is 1 for exactly one cycle, and status bit 4 is 1.
- R4: A step-class command is admitted whatever the level of `drv_ready`. Status bit 7 always shows the inverse of `drv_ready`.
- R5: A write command with `drv_ready` high and `drv_wprot_n` low is not admitted. On the next cycle `busy` is 0, `intrq` is 1, `terminate` is 1 and status bit 6 is 1.
- R6: While a write is busy, `wgate` high together with `drv_wfault_n` low ends the command on the next cycle: `busy` 0, `drq` 0, `intrq` 1, `terminate` 1, status bit 5 is 1. With `wgate` low, `drv_wfault_n` has no effect.
- R7: In a read, `byte_ready` sets `drq` and `host_data_rd` clears it. `host_data_wr` leaves it unchanged. Status bit 1 mirrors `drq`.
- R8: In a write, `byte_taken` sets `drq` and `host_data_wr` clears it. `host_data_rd` leaves it unchanged.
- R9: `cmd_done` while busy clears `busy` and `drq` and sets `intrq` on the next cycle. `host_status_rd` clears `intrq`, but a completion in the same cycle wins.
- R10: `side_sel` takes `cmd_side` on every read or write command write made while idle, including rejected ones. A step-class command leaves it unchanged.
- R11: A command write while busy is ignored: `busy`, `intrq`, `drq` and `side_sel` keep their values.
- R12: Each command write while idle replaces status bits 4 to 6 with that command's rejection reason, or with zeros if it is admitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_wr | input | 1 | Host writes the command register (one-cycle strobe) |
| cmd_code | input | 2 | Command class of the write: 0x step, 10 read, 11 write |
| cmd_side | input | 1 | Side flag carried by the command |
| cmd_done | input | 1 | Sequencer reports normal completion |
| byte_ready | input | 1 | Read: a finished byte entered the data register |
| byte_taken | input | 1 | Write: the data register was moved to the shifter |
| host_data_rd | input | 1 | Host reads the data register |
| host_data_wr | input | 1 | Host loads the data register |
| host_status_rd | input | 1 | Host reads the status register |
| drv_ready | input | 1 | Drive ready, high active |
| drv_wprot_n | input | 1 | Write protect, low means protected |
| drv_wfault_n | input | 1 | Write fault, low means fault |
| wgate | input | 1 | Write gate currently open |
| drq | output | 1 | Data request to the host |
| intrq | output | 1 | Interrupt request to the host |
| side_sel | output | 1 | Side select to the drive |
| terminate | output | 1 | One-cycle strobe: command ended abnormally |
| busy | output | 1 | Command in progress |
| status | output | 8 | Status byte (bits 0,1,4,5,6,7 defined, 2,3 zero) |

## Verification
The bench targets the edges of admission. A step command with the drive not ready must still run; a design that applies the ready check to all classes would leave busy low. A write to a protected disk must report bit 6 and not bit 4; a design that mixes up the two checks would show the wrong bit. A fault pulse with the write gate closed must be ignored; a design that forgot the gate would end the write early. The bench also tests which event wins in the same cycle. A completion that coincides with a status read must leave the interrupt set; a wrong priority would lose the interrupt. A command written while busy must not disturb the side output or the flags, and a design without that guard would relatch the side.

// File: rtl/fdc_flags_pkg.sv
// Shared types and status-bit layout for the host handshake block.
package fdc_flags_pkg;
    localparam int STAT_W  = 8;
    localparam int CODE_W  = 2;
    localparam int ST_BUSY = 0;
    localparam int ST_DRQ  = 1;
    localparam int ST_NRDY = 4;
    localparam int ST_WFLT = 5;
    localparam int ST_WPRT = 6;
    localparam int ST_DRDY = 7;

    typedef enum logic [1:0] {
        KIND_STEP  = 2'b00,
        KIND_READ  = 2'b10,
        KIND_WRITE = 2'b11
    } cmd_kind_t;

    typedef struct packed {
        logic nrdy;
        logic wflt;
        logic wprt;
    } reason_t;

    // Map a raw command code onto its class; bit 1 clear means step class.
    function automatic cmd_kind_t kind_of(input logic [CODE_W-1:0] code);
        if (!code[1])     return KIND_STEP;
        else if (code[0]) return KIND_WRITE;
        else              return KIND_READ;
    endfunction
endpackage

// File: rtl/fdc_admit.sv
// Admission check for a newly written command.
// Purely combinational. Assumes the drive pins are already synchronised.
// Step class always passes. A read needs ready. A write needs ready and no protection.
module fdc_admit
    import fdc_flags_pkg::*;
(
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              drv_ready,
    input  logic              drv_wprot_n,
    output cmd_kind_t         kind,
    output logic              accept,
    output reason_t           why
);
    // Decide the class, then the rejection reason that applies to it.
    always_comb begin
        kind        = kind_of(cmd_code);
        why         = '0;
        if (kind != KIND_STEP && !drv_ready)
            why.nrdy = 1'b1;
        else if (kind == KIND_WRITE && !drv_wprot_n)
            why.wprt = 1'b1;
        accept = !(why.nrdy || why.wprt);
    end
endmodule

// File: rtl/fdc_cmd_track.sv
// Command lifetime tracker: busy, active class, side latch, reason flags and the terminate strobe.
// Assumes cmd_done and the fault pin only matter while busy.
// It exports the start and finish events that drive the request flags.
module fdc_cmd_track
    import fdc_flags_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cmd_wr,
    input  cmd_kind_t kind,
    input  logic      accept,
    input  reason_t   why,
    input  logic      cmd_side,
    input  logic      cmd_done,
    input  logic      wgate,
    input  logic      drv_wfault_n,
    output logic      busy,
    output cmd_kind_t cur_kind,
    output logic      side_sel,
    output reason_t   flags,
    output logic      terminate,
    output logic      start_evt,
    output logic      finish_evt
);
    logic take;
    logic fault_hit;
    logic done_hit;

    // Event decode for this cycle.
    always_comb begin
        take       = cmd_wr && !busy;
        fault_hit  = busy && (cur_kind == KIND_WRITE) && wgate && !drv_wfault_n;
        done_hit   = busy && cmd_done && !fault_hit;
        start_evt  = take;
        finish_evt = (take && !accept) || fault_hit || done_hit;
    end

    // Busy flag and the class of the running command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            cur_kind <= KIND_STEP;
        end else if (take) begin
            busy <= accept;
            if (accept)
                cur_kind <= kind;
        end else if (fault_hit || done_hit) begin
            busy <= 1'b0;
        end
    end

    // Side latch: updated only by read or write command writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            side_sel <= 1'b0;
        else if (take && kind != KIND_STEP)
            side_sel <= cmd_side;
    end

    // Reason flags: replaced at each command write, fault added during a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flags <= '0;
        else if (take)
            flags <= why;
        else if (fault_hit)
            flags.wflt <= 1'b1;
    end

    // One-cycle strobe for any abnormal end.
    always_ff @(posedge clk) begin
        if (!rst_n)
            terminate <= 1'b0;
        else
            terminate <= (take && !accept) || fault_hit;
    end

    // R6: a write fault under an open gate ends the command.
    a_r6_fault_ends_write: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cur_kind == KIND_WRITE && wgate && !drv_wfault_n)
        |=> (!busy && terminate && flags.wflt));

    // R11: a command write while busy keeps busy and the side latch.
    a_r11_busy_ignores_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_wr && !cmd_done && !(wgate && !drv_wfault_n))
        |=> (busy && $stable(side_sel)));

    // R10: a step-class command never moves the side latch.
    a_r10_step_keeps_side: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && kind == KIND_STEP) |=> $stable(side_sel));
endmodule

// File: rtl/fdc_req_flags.sv
// Data-request and interrupt-request flags.
// Assumes start_evt and finish_evt come from the command tracker in the same cycle as the triggering input.
// A finish event takes priority over a start or a host clear.
module fdc_req_flags
    import fdc_flags_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      busy,
    input  cmd_kind_t cur_kind,
    input  logic      byte_ready,
    input  logic      byte_taken,
    input  logic      host_data_rd,
    input  logic      host_data_wr,
    input  logic      host_status_rd,
    input  logic      start_evt,
    input  logic      finish_evt,
    output logic      drq,
    output logic      intrq
);
    logic is_rd;
    logic is_wr;

    // Direction of the running transfer.
    always_comb begin
        is_rd = busy && (cur_kind == KIND_READ);
        is_wr = busy && (cur_kind == KIND_WRITE);
    end

    // Data request: set by the data path, cleared by host service or command boundaries.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drq <= 1'b0;
        else if (start_evt || finish_evt)
            drq <= 1'b0;
        else if ((is_rd && byte_ready) || (is_wr && byte_taken))
            drq <= 1'b1;
        else if ((is_rd && host_data_rd) || (is_wr && host_data_wr))
            drq <= 1'b0;
    end

    // Interrupt request: set on any finish, cleared by command write or status read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            intrq <= 1'b0;
        else if (finish_evt)
            intrq <= 1'b1;
        else if (start_evt || host_status_rd)
            intrq <= 1'b0;
    end

    // R9: a finish always leaves the interrupt raised.
    a_r9_finish_sets_intrq: assert property (@(posedge clk) disable iff (!rst_n)
        finish_evt |=> intrq);

    // R7: in a read, the host reading the data register drops the request.
    a_r7_read_service: assert property (@(posedge clk) disable iff (!rst_n)
        (is_rd && host_data_rd && !byte_ready) |=> !drq);
endmodule

// File: rtl/fdc_hostflags.sv
// Top: host handshake and command admission for a floppy controller.
// Assumes every input is synchronous to clk and every strobe lasts one cycle.
// Builds the status byte from the tracker and flag state.
module fdc_hostflags
    import fdc_flags_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_wr,
    input  logic [CODE_W-1:0] cmd_code,
    input  logic              cmd_side,
    input  logic              cmd_done,
    input  logic              byte_ready,
    input  logic              byte_taken,
    input  logic              host_data_rd,
    input  logic              host_data_wr,
    input  logic              host_status_rd,
    input  logic              drv_ready,
    input  logic              drv_wprot_n,
    input  logic              drv_wfault_n,
    input  logic              wgate,
    output logic              drq,
    output logic              intrq,
    output logic              side_sel,
    output logic              terminate,
    output logic              busy,
    output logic [STAT_W-1:0] status
);
    cmd_kind_t kind;
    cmd_kind_t cur_kind;
    logic      accept;
    reason_t   why;
    reason_t   flags;
    logic      start_evt;
    logic      finish_evt;

    fdc_admit u_admit (
        .cmd_code    (cmd_code),
        .drv_ready   (drv_ready),
        .drv_wprot_n (drv_wprot_n),
        .kind        (kind),
        .accept      (accept),
        .why         (why)
    );

    fdc_cmd_track u_track (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_wr       (cmd_wr),
        .kind         (kind),
        .accept       (accept),
        .why          (why),
        .cmd_side     (cmd_side),
        .cmd_done     (cmd_done),
        .wgate        (wgate),
        .drv_wfault_n (drv_wfault_n),
        .busy         (busy),
        .cur_kind     (cur_kind),
        .side_sel     (side_sel),
        .flags        (flags),
        .terminate    (terminate),
        .start_evt    (start_evt),
        .finish_evt   (finish_evt)
    );

    fdc_req_flags u_req (
        .clk            (clk),
        .rst_n          (rst_n),
        .busy           (busy),
        .cur_kind       (cur_kind),
        .byte_ready     (byte_ready),
        .byte_taken     (byte_taken),
        .host_data_rd   (host_data_rd),
        .host_data_wr   (host_data_wr),
        .host_status_rd (host_status_rd),
        .start_evt      (start_evt),
        .finish_evt     (finish_evt),
        .drq            (drq),
        .intrq          (intrq)
    );

    // Status byte: each position picks its source, unused positions read zero.
    for (genvar b = 0; b < STAT_W; b++) begin : g_stat
        if (b == ST_BUSY)      begin : g_busy assign status[b] = busy;       end
        else if (b == ST_DRQ)  begin : g_drq  assign status[b] = drq;        end
        else if (b == ST_NRDY) begin : g_nrdy assign status[b] = flags.nrdy; end
        else if (b == ST_WFLT) begin : g_wflt assign status[b] = flags.wflt; end
        else if (b == ST_WPRT) begin : g_wprt assign status[b] = flags.wprt; end
        else if (b == ST_DRDY) begin : g_drdy assign status[b] = !drv_ready; end
        else                   begin : g_zero assign status[b] = 1'b0;       end
    end

    // R3: a data command with the drive not ready is rejected with bit 4.
    a_r3_not_ready_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_code[1] && !drv_ready)
        |=> (!busy && intrq && terminate && status[ST_NRDY]));

    // R4: a step-class command is always admitted.
    a_r4_step_admitted: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && !cmd_code[1]) |=> busy);

    // R5: write to protected medium is rejected with bit 6.
    a_r5_protect_rejects: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !busy && cmd_code == 2'b11 && drv_ready && !drv_wprot_n)
        |=> (!busy && intrq && status[ST_WPRT]));

    // R8: a data request only exists while a command runs.
    a_r8_drq_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        drq |-> busy);

    // R9: completion while busy clears busy and drq, raises intrq.
    a_r9_done_completes: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_done) |=> (!busy && !drq && intrq));
endmodule

// File: tb/fdc_hostflags_bench.sv
// Directed bench for fdc_hostflags: one task per scenario, each checks its own results.
module fdc_hostflags_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_wr = 0, cmd_side = 0, cmd_done = 0;
    logic [1:0] cmd_code = 2'b00;
    logic       byte_ready = 0, byte_taken = 0;
    logic       host_data_rd = 0, host_data_wr = 0, host_status_rd = 0;
    logic       drv_ready = 1, drv_wprot_n = 1, drv_wfault_n = 1, wgate = 0;
    logic       drq, intrq, side_sel, terminate, busy;
    logic [7:0] status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    fdc_hostflags u_fdc_hostflags (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
        .cmd_side(cmd_side), .cmd_done(cmd_done), .byte_ready(byte_ready),
        .byte_taken(byte_taken), .host_data_rd(host_data_rd),
        .host_data_wr(host_data_wr), .host_status_rd(host_status_rd),
        .drv_ready(drv_ready), .drv_wprot_n(drv_wprot_n),
        .drv_wfault_n(drv_wfault_n), .wgate(wgate), .drq(drq), .intrq(intrq),
        .side_sel(side_sel), .terminate(terminate), .busy(busy), .status(status)
    );

    task automatic check(input logic actual, input logic expected, input string what);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b", what, actual, expected);
        end
    endtask

    // Advance one edge and settle away from it.
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic issue(input logic [1:0] code, input logic side);
        cmd_code = code; cmd_side = side; cmd_wr = 1;
        tick();
        cmd_wr = 0;
    endtask

    task automatic pulse_done();
        cmd_done = 1; tick(); cmd_done = 0;
    endtask

    task automatic t_reset();
        check(drq, 0, "R1 drq");
        check(intrq, 0, "R1 intrq");
        check(busy, 0, "R1 busy");
        check(side_sel, 0, "R1 side_sel");
        check(terminate, 0, "R1 terminate");
        check(status[6:0] == 7'd0, 1, "R1 status low bits");
    endtask

    task automatic t_step_not_ready();
        drv_ready = 0;
        issue(2'b00, 1);
        check(busy, 1, "R4 step admitted without ready");
        check(status[0], 1, "R2 status busy bit");
        check(status[7], 1, "R4 status bit7 inverted ready");
        check(side_sel, 0, "R10 step keeps side");
        drv_ready = 1; #1;
        check(status[7], 0, "R4 status bit7 follows ready");
        pulse_done();
        check(busy, 0, "R9 done clears busy");
        check(intrq, 1, "R9 done sets intrq");
        host_status_rd = 1; tick(); host_status_rd = 0;
        check(intrq, 0, "R9 status read clears intrq");
    endtask

    task automatic t_read_not_ready();
        drv_ready = 0;
        issue(2'b10, 1);
        check(busy, 0, "R3 read rejected");
        check(intrq, 1, "R3 intrq");
        check(terminate, 1, "R3 terminate");
        check(status[4], 1, "R3 not-ready bit");
        check(side_sel, 1, "R10 rejected read latches side");
        tick();
        check(terminate, 0, "R3 terminate one cycle");
        drv_ready = 1;
    endtask

    task automatic t_write_protect();
        drv_wprot_n = 0;
        issue(2'b11, 0);
        check(busy, 0, "R5 write rejected");
        check(status[6], 1, "R5 protect bit");
        check(status[4], 0, "R12 not-ready bit replaced");
        check(intrq, 1, "R5 intrq");
        check(terminate, 1, "R5 terminate");
        check(side_sel, 0, "R10 side follows write");
        drv_wprot_n = 1;
    endtask

    task automatic t_read_transfer();
        issue(2'b10, 1);
        check(busy, 1, "R2 read admitted");
        check(intrq, 0, "R2 command write clears intrq");
        check(status[6], 0, "R12 protect bit cleared");
        byte_ready = 1; tick(); byte_ready = 0;
        check(drq, 1, "R7 byte_ready sets drq");
        check(status[1], 1, "R7 status mirrors drq");
        host_data_wr = 1; tick(); host_data_wr = 0;
        check(drq, 1, "R7 data write ignored in read");
        host_data_rd = 1; tick(); host_data_rd = 0;
        check(drq, 0, "R7 data read clears drq");
        byte_ready = 1; tick(); byte_ready = 0;
        issue(2'b11, 0);
        check(busy, 1, "R11 busy kept");
        check(side_sel, 1, "R11 side kept");
        check(drq, 1, "R11 drq kept");
        check(intrq, 0, "R11 intrq kept");
        cmd_done = 1; host_status_rd = 1; tick(); cmd_done = 0; host_status_rd = 0;
        check(intrq, 1, "R9 completion beats status read");
        check(drq, 0, "R9 done clears drq");
        check(busy, 0, "R9 busy cleared");
    endtask

    task automatic t_write_fault();
        issue(2'b11, 1);
        check(busy, 1, "R2 write admitted");
        byte_taken = 1; tick(); byte_taken = 0;
        check(drq, 1, "R8 byte_taken sets drq");
        host_data_rd = 1; tick(); host_data_rd = 0;
        check(drq, 1, "R8 data read ignored in write");
        host_data_wr = 1; tick(); host_data_wr = 0;
        check(drq, 0, "R8 data write clears drq");
        byte_taken = 1; tick(); byte_taken = 0;
        drv_wfault_n = 0; wgate = 0; tick();
        check(busy, 1, "R6 fault ignored with gate closed");
        check(status[5], 0, "R6 no fault bit with gate closed");
        wgate = 1; tick(); wgate = 0; drv_wfault_n = 1;
        check(busy, 0, "R6 fault ends write");
        check(drq, 0, "R6 fault clears drq");
        check(intrq, 1, "R6 intrq");
        check(terminate, 1, "R6 terminate");
        check(status[5], 1, "R6 fault bit");
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        tick(); tick();
        t_reset();
        rst_n = 1; tick();
        t_step_not_ready();
        t_read_not_ready();
        t_write_protect();
        t_read_transfer();
        t_write_fault();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule